// File: doc/BRIEF.md
# Undervoltage Reset Supervisor Filter

This block turns the raw output of an analog supply comparator into a clean, time-qualified supply-good level. It also produces the active-low reset level that goes to the system. The comparator bit first passes through a short flip-flop synchroniser. A single run-length counter then qualifies every disagreement between the synchronised bit and the current supply-good level. A move to good needs a long stable run, and a move to bad needs a shorter stable run. Any run that is too short is discarded without effect.

The reset output is held asserted whenever supply-good is low. Any other cause of a supply collapse, such as thermal shutdown or current limiting, reaches the reset output only through the comparator bit. While the supply is good, a watchdog reset request stretches into a reset pulse of the release duration. The supply-good level is meant to serve as the reset for the watchdog and the other digital logic. For that reason, requests that arrive while the supply is bad are dropped.

Top module: `uvs_supervisor`

## Requirements
- R1: While `rst_n` is low, `vdd_good` is 0 and `reset_n` is 0, asynchronously and independent of the clock.
- R2: With `vdd_good` at 0, `vdd_good` becomes 1 right after the (REL_CYCLES+2)-th consecutive rising edge at which `vdd_ok_raw` (1 = supply above threshold) is sampled 1. Two edges are synchroniser latency and REL_CYCLES are qualification.
- R3: With `vdd_good` at 1, `vdd_good` becomes 0 right after the (AST_CYCLES+2)-th consecutive rising edge at which `vdd_ok_raw` is sampled 0.
- R4: A low run of `vdd_ok_raw` of fewer than AST_CYCLES samples, with high samples around it, leaves `vdd_good` and `reset_n` unchanged.
- R5: A high run of `vdd_ok_raw` of fewer than REL_CYCLES samples while `vdd_good` is 0 leaves `vdd_good` at 0 and `reset_n` at 0.
- R6: `reset_n` is registered. At each rising edge it loads (`vdd_good` before that edge) AND NOT (watchdog hold). It therefore falls one edge after `vdd_good` falls and rises one edge after `vdd_good` rises when no watchdog hold is active.
- R7: `wd_req` sampled 1 at a rising edge while `vdd_good` is 1 drives `reset_n` to 0 right after that edge. `reset_n` then stays 0 until REL_CYCLES edges after the last edge at which `wd_req` was sampled 1, and is 1 again right after that edge.
- R8: `wd_req` sampled while `vdd_good` is 0 is ignored. It leaves no hold behind once the supply is good again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| vdd_ok_raw | input | 1 | Raw comparator bit, 1 = supply above threshold, asynchronous |
| wd_req | input | 1 | Watchdog reset request, synchronous to clk, active high |
| vdd_good | output | 1 | Qualified supply-good level |
| reset_n | output | 1 | System reset level, active low |

## Verification
The assertions take the comparator bit as arbitrary but treat `wd_req` as a signal that already lives in the `clk` domain. They also assume that REL_CYCLES and AST_CYCLES are at least 1 and that the synchroniser has at least two stages. The bench changes both inputs only on the falling clock edge, so each input holds one value at every rising edge and the sample counts in R2 to R5 are exact. Power-on reset is applied and released on falling edges, so no qualification run is cut off in the middle of an edge.

// File: rtl/uvs_pkg.sv
package uvs_pkg;

    typedef enum logic {
        SUPPLY_BAD  = 1'b0,
        SUPPLY_GOOD = 1'b1
    } supply_e;

    // Bits needed to hold the values 0..n, never fewer than one.
    function automatic int unsigned cnt_bits(input int unsigned n);
        int unsigned w;
        w = $clog2(n + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/uvs_sync.sv
module uvs_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/uvs_qual.sv
module uvs_qual
    import uvs_pkg::*;
#(
    parameter int unsigned REL_CYCLES = 64,
    parameter int unsigned AST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic good
);

    localparam int unsigned      LMAX     = (REL_CYCLES > AST_CYCLES) ? REL_CYCLES : AST_CYCLES;
    localparam int unsigned      CW       = cnt_bits(LMAX);
    localparam logic [CW-1:0]    REL_LAST = CW'(REL_CYCLES - 1);
    localparam logic [CW-1:0]    AST_LAST = CW'(AST_CYCLES - 1);
    localparam logic [CW-1:0]    REL_W    = CW'(REL_CYCLES);
    localparam logic [CW-1:0]    AST_W    = CW'(AST_CYCLES);
    localparam logic [CW-1:0]    SAT_W    = CW'(LMAX);

    typedef struct packed {
        supply_e       lvl;
        logic [CW-1:0] cnt;
    } qual_t;

    qual_t   st_d;
    qual_t   st_q;
    supply_e seen;
    logic [CW-1:0] last;

    always_comb begin
        st_d = st_q;
        seen = supply_e'(level_in);
        last = (st_q.lvl == SUPPLY_GOOD) ? AST_LAST : REL_LAST;
        if (seen != st_q.lvl) begin
            if (st_q.cnt == last) begin
                st_d.lvl = seen;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lvl: SUPPLY_BAD, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign good = (st_q.lvl == SUPPLY_GOOD);

    // Independent run-length trackers of the synchronised level, used by the checks below.
    logic [CW-1:0] run_hi_q;
    logic [CW-1:0] run_lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_hi_q <= '0;
            run_lo_q <= '0;
        end else begin
            run_hi_q <= !level_in ? '0 : ((run_hi_q == SAT_W) ? run_hi_q : run_hi_q + 1'b1);
            run_lo_q <=  level_in ? '0 : ((run_lo_q == SAT_W) ? run_lo_q : run_lo_q + 1'b1);
        end
    end

    AST_RISE_NEEDS_LONG_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(good) |-> (run_hi_q >= REL_W)); // R2

    AST_FALL_NEEDS_SHORT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(good) |-> (run_lo_q >= AST_W)); // R3

endmodule

// File: rtl/uvs_rstgen.sv
module uvs_rstgen
    import uvs_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic good,
    input  logic wd_req,
    output logic reset_n
);

    localparam int unsigned   HW        = cnt_bits(HOLD_CYCLES);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

    typedef struct packed {
        logic          act;
        logic [HW-1:0] cnt;
        logic          rstn;
    } rg_t;

    rg_t st_d;
    rg_t st_q;

    always_comb begin
        st_d = st_q;
        if (!good) begin
            st_d.act = 1'b0;
            st_d.cnt = '0;
        end else if (wd_req) begin
            st_d.act = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.act) begin
            if (st_q.cnt == HOLD_LAST) begin
                st_d.act = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        st_d.rstn = good && !st_d.act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{act: 1'b0, cnt: '0, rstn: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign reset_n = st_q.rstn;

    AST_BAD_SUPPLY_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !good |=> !reset_n); // R6

    AST_RELEASE_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_n) |-> $past(good)); // R6

    AST_WD_PULLS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (good && wd_req) |=> !reset_n); // R7

endmodule

// File: rtl/uvs_supervisor.sv
module uvs_supervisor #(
    parameter int unsigned REL_CYCLES  = 64,
    parameter int unsigned AST_CYCLES  = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vdd_ok_raw,
    input  logic wd_req,
    output logic vdd_good,
    output logic reset_n
);

    logic ok_sync;
    logic good_lvl;

    uvs_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (vdd_ok_raw),
        .dout  (ok_sync)
    );

    uvs_qual #(.REL_CYCLES(REL_CYCLES), .AST_CYCLES(AST_CYCLES)) i_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (ok_sync),
        .good     (good_lvl)
    );

    uvs_rstgen #(.HOLD_CYCLES(REL_CYCLES)) i_rstgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .good    (good_lvl),
        .wd_req  (wd_req),
        .reset_n (reset_n)
    );

    assign vdd_good = good_lvl;

    AST_RESET_IN_RESET: assert property (@(posedge clk)
        !rst_n |-> (!vdd_good && !reset_n)); // R1

endmodule

// File: tb/test_uvs_supervisor.sv
module test_uvs_supervisor;

    localparam int unsigned REL = 64;
    localparam int unsigned AST = 8;

    typedef struct packed {
        logic       ok;
        logic       wd;
        logic [7:0] n;
        logic       eg;
        logic       er;
    } row_t;

    localparam int NROWS = 22;
    localparam row_t TBL [NROWS] = '{
        '{1'b1, 1'b0, 8'(REL+1), 1'b0, 1'b0},  // R2 one sample short
        '{1'b1, 1'b0, 8'd1,      1'b1, 1'b0},  // R2 rises, R6 lag
        '{1'b1, 1'b0, 8'd1,      1'b1, 1'b1},  // R6 release
        '{1'b0, 1'b0, 8'(AST-1), 1'b1, 1'b1},  // R4 dip in progress
        '{1'b1, 1'b0, 8'd10,     1'b1, 1'b1},  // R4 dip of AST-1 ignored
        '{1'b0, 1'b0, 8'(AST+1), 1'b1, 1'b1},  // R3 not yet
        '{1'b0, 1'b0, 8'd1,      1'b0, 1'b1},  // R3 falls, R6 lag
        '{1'b0, 1'b0, 8'd1,      1'b0, 1'b0},  // R6 follows
        '{1'b1, 1'b0, 8'(REL-1), 1'b0, 1'b0},  // R5 short good pulse
        '{1'b0, 1'b0, 8'd10,     1'b0, 1'b0},  // R5 pulse ignored
        '{1'b1, 1'b0, 8'(REL+2), 1'b1, 1'b0},  // R2
        '{1'b1, 1'b0, 8'd1,      1'b1, 1'b1},  // R6
        '{1'b1, 1'b1, 8'd1,      1'b1, 1'b0},  // R7 request
        '{1'b1, 1'b0, 8'(REL-2), 1'b1, 1'b0},  // R7 hold
        '{1'b1, 1'b0, 8'd1,      1'b1, 1'b0},  // R7 last low edge
        '{1'b1, 1'b0, 8'd1,      1'b1, 1'b1},  // R7 released
        '{1'b1, 1'b1, 8'd3,      1'b1, 1'b0},  // R7 held request
        '{1'b1, 1'b0, 8'(REL-1), 1'b1, 1'b0},  // R7 timed from last request
        '{1'b1, 1'b0, 8'd1,      1'b1, 1'b1},  // R7 released
        '{1'b0, 1'b0, 8'(AST+3), 1'b0, 1'b0},  // R3 and R6
        '{1'b0, 1'b1, 8'd5,      1'b0, 1'b0},  // R8 request while bad
        '{1'b1, 1'b0, 8'(REL+3), 1'b1, 1'b1}   // R8 no leftover hold
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vdd_ok_raw = 1'b0;
    logic wd_req = 1'b0;
    logic vdd_good;
    logic reset_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    uvs_supervisor #(.REL_CYCLES(REL), .AST_CYCLES(AST), .SYNC_STAGES(2)) i_uvs_supervisor (
        .clk        (clk),
        .rst_n      (rst_n),
        .vdd_ok_raw (vdd_ok_raw),
        .wd_req     (wd_req),
        .vdd_good   (vdd_good),
        .reset_n    (reset_n)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog run did not complete actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        @(negedge clk);
        check("R1", "vdd_good in reset", vdd_good, 1'b0);
        check("R1", "reset_n in reset", reset_n, 1'b0);
        rst_n = 1'b1;

        // Table walk: drive at a falling edge, count rising edges, sample at a falling edge.
        for (int i = 0; i < NROWS; i++) begin
            vdd_ok_raw = TBL[i].ok;
            wd_req     = TBL[i].wd;
            repeat (int'(TBL[i].n)) @(posedge clk);
            @(negedge clk);
            check($sformatf("R2-8 row %0d", i), "vdd_good", vdd_good, TBL[i].eg);
            check($sformatf("R6 row %0d", i), "reset_n", reset_n, TBL[i].er);
        end
        wd_req = 1'b0;

        // R1: asynchronous reset in the middle of a good supply
        rst_n = 1'b0;
        #1;
        check("R1", "vdd_good async", vdd_good, 1'b0);
        check("R1", "reset_n async", reset_n, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: requalification after reset with the supply already good
        repeat (REL + 1) @(posedge clk);
        @(negedge clk);
        check("R2", "vdd_good before release", vdd_good, 1'b0);
        repeat (1) @(posedge clk);
        @(negedge clk);
        check("R2", "vdd_good after release", vdd_good, 1'b1);
        check("R6", "reset_n lags", reset_n, 1'b0);
        repeat (1) @(posedge clk);
        @(negedge clk);
        check("R6", "reset_n released", reset_n, 1'b1);

        // R8 then R7: request while bad ignored, request while good honoured
        vdd_ok_raw = 1'b0;
        repeat (AST + 3) @(posedge clk);
        @(negedge clk);
        check("R3", "vdd_good dropped", vdd_good, 1'b0);
        vdd_ok_raw = 1'b1;
        wd_req = 1'b1;
        repeat (REL + 3) @(posedge clk);
        @(negedge clk);
        check("R8", "vdd_good back", vdd_good, 1'b1);
        check("R7", "reset_n held by live request", reset_n, 1'b0);
        wd_req = 1'b0;
        repeat (REL) @(posedge clk);
        @(negedge clk);
        check("R7", "reset_n after hold", reset_n, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule